// File: doc/BRIEF.md
# Periodic Multichannel Snapshot Sampler

This block takes a picture of a wide bank of isolated digital pulse lines at a fixed rate. A divider in the block turns the system clock into a sampling tick. The default is one tick every 6000 cycles of a 6 MHz clock, which gives one tick per millisecond. On each tick, every channel is copied into one holding register in the same clock cycle. That copy stays unchanged until the next tick. The capture error is therefore never more than one sample period.

Each capture raises a level interrupt towards a host microcontroller. The host then fetches the picture over a byte-wide register bus. The snapshot appears as consecutive bytes starting at address 0. The next address holds a combined control/status byte. The host clears the interrupt in one of two ways: it reads the last snapshot byte, or it writes a clear bit. If a tick arrives before the host has done so, a sticky overrun flag records the miss. The new snapshot still replaces the old one.

The pulse inputs are asynchronous to the clock. A two-stage synchronizer therefore sits in front of the holding register. A high input means the pulse is active, and the block copies it without inversion.

Top module: `pulse_snapshot_sampler`

## Requirements
- R1: A synchronous active-high `rst` clears the divider, the snapshot, the interrupt, the overrun flag and the enable bit. After reset, `irq_o` is 0, every snapshot byte reads 0 and the status byte reads 0.
- R2: While sampling is enabled, a tick occurs every `TICK_DIV` cycles. The first `irq_o` rise comes exactly `TICK_DIV` clock edges after the edge that accepts the enabling write.
- R3: On a tick, all `N_CH` channels are captured in one cycle and held until the next tick. Channel 8k+b reads back as bit b of address k.
- R4: A high input is read back as 1 and a low input as 0, with no inversion.
- R5: `irq_o` rises on the clock edge that loads the snapshot.
- R6: Reading address `N_BYTES-1` (9 by default) clears `irq_o`. Reading any other snapshot address leaves it set.
- R7: Writing address `N_BYTES` (10) with bit 1 set clears `irq_o`. Bit 0 of every write to that address sets the enable.
- R8: A tick while `irq_o` is still set sets a sticky overrun flag. The new data still replaces the old snapshot.
- R9: The overrun flag stays set until address 10 is written with bit 2 set, or until reset.
- R10: While the enable is 0, the divider is held at zero and no tick or interrupt occurs. Enabling again restarts the full `TICK_DIV` count.
- R11: Reading address 10 returns the enable in bit 0, the interrupt in bit 1 and the overrun flag in bit 2, with zeros above. Addresses above 10 read as 0.
- R12: An input change is captured by a tick only if it reaches the pin before the clock edge two edges ahead of the capturing edge. A change after that edge appears at the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | N_CH | Asynchronous pulse channels, high = active |
| bus_addr | input | ADDR_W | Host register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level-high snapshot-ready interrupt |

## Verification
The assertions assume the host raises `bus_rd` and `bus_wr` for single cycles and never both at once. They also assume `pulse_in` is only sampled through the synchronizer. The stimulus drives every bus strobe for exactly one cycle on the falling edge and changes the pulse pattern only between rising edges. Apart from the deliberate late-change case for R12, a new pattern is always applied well before the next capture. This keeps each expected snapshot unambiguous.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam int unsigned CTL_EN      = 0;
  localparam int unsigned CTL_IRQ_CLR = 1;
  localparam int unsigned CTL_OVR_CLR = 2;

  localparam int unsigned STS_EN  = 0;
  localparam int unsigned STS_IRQ = 1;
  localparam int unsigned STS_OVR = 2;

  function automatic int unsigned bytes_for(input int unsigned bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction

  function automatic int unsigned width_for(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  function automatic logic count_done(input int unsigned cnt, input int unsigned period);
    return cnt == period - 1;
  endfunction

endpackage

// File: rtl/pss_tick_div.sv
module pss_tick_div #(
  parameter int unsigned TICK_DIV = 6000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  import pss_pkg::*;

  localparam int unsigned CW = width_for(TICK_DIV);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = count_done(32'(cnt_q), TICK_DIV);
  assign tick   = en && at_end;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int unsigned W      = 80,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctl,
  input  logic [2:0] wbits,
  input  logic       rd_last,
  input  logic       tick,
  output logic       en,
  output logic       irq,
  output logic       ovr,
  output logic       irq_clr,
  output logic       ovr_clr
);
  import pss_pkg::*;

  assign irq_clr = rd_last || (wr_ctl && wbits[CTL_IRQ_CLR]);
  assign ovr_clr = wr_ctl && wbits[CTL_OVR_CLR];

  always_ff @(posedge clk) begin
    if (rst)         en <= 1'b0;
    else if (wr_ctl) en <= wbits[CTL_EN];
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (tick)    irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)               ovr <= 1'b0;
    else if (tick && irq)  ovr <= 1'b1;
    else if (ovr_clr)      ovr <= 1'b0;
  end

endmodule

// File: rtl/pulse_snapshot_sampler.sv
module pulse_snapshot_sampler #(
  parameter int unsigned N_CH     = 80,
  parameter int unsigned TICK_DIV = 6000,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   pulse_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o
);
  import pss_pkg::*;

  localparam int unsigned N_BYTES   = bytes_for(N_CH);
  localparam int unsigned LAST_ADDR = N_BYTES - 1;
  localparam int unsigned STAT_ADDR = N_BYTES;
  localparam int unsigned PAD_W     = N_BYTES * BYTE_W;

  logic [N_CH-1:0]   sync_q;
  logic [N_CH-1:0]   snap_q;
  logic [PAD_W-1:0]  snap_pad;
  logic              tick_w;
  logic              en_w;
  logic              irq_w;
  logic              ovr_w;
  logic              irq_clr_w;
  logic              ovr_clr_w;
  logic              rd_last_w;
  logic              wr_ctl_w;
  logic [7:0]        status_w;
  logic              unused_wbits;

  assign unused_wbits = &{1'b0, bus_wdata[7:3]};

  assign rd_last_w = bus_rd && (bus_addr == ADDR_W'(LAST_ADDR));
  assign wr_ctl_w  = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));

  pss_sync #(.W(N_CH), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pulse_in),
    .q   (sync_q)
  );

  pss_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (en_w),
    .tick (tick_w)
  );

  pss_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctl  (wr_ctl_w),
    .wbits   (bus_wdata[2:0]),
    .rd_last (rd_last_w),
    .tick    (tick_w),
    .en      (en_w),
    .irq     (irq_w),
    .ovr     (ovr_w),
    .irq_clr (irq_clr_w),
    .ovr_clr (ovr_clr_w)
  );

  always_ff @(posedge clk) begin
    if (rst)         snap_q <= '0;
    else if (tick_w) snap_q <= sync_q;
  end

  assign snap_pad = PAD_W'(snap_q);

  always_comb begin
    status_w          = '0;
    status_w[STS_EN]  = en_w;
    status_w[STS_IRQ] = irq_w;
    status_w[STS_OVR] = ovr_w;
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < int'(N_BYTES); b++) begin
      if (bus_addr == ADDR_W'(b)) bus_rdata = snap_pad[b*BYTE_W +: BYTE_W];
    end
    if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata = status_w;
  end

  assign irq_o = irq_w;

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int unsigned N_CH     = 80,
  parameter int unsigned TICK_DIV = 6000
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic            en,
  input logic            irq,
  input logic            ovr,
  input logic            irq_clr,
  input logic            ovr_clr,
  input logic [N_CH-1:0] sync_q,
  input logic [N_CH-1:0] snap
);

  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (rst || !en || tick) gap_q <= 0;
    else                    gap_q <= gap_q + 1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap_q == TICK_DIV - 1);

  a_r10_no_tick_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);

  a_r5_irq_with_load: assert property (@(posedge clk) disable iff (rst)
    tick |=> irq);

  a_r3_snap_load: assert property (@(posedge clk) disable iff (rst)
    tick |=> snap == $past(sync_q));

  a_r3_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(snap));

  a_r6_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !tick) |=> !irq);

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (tick && irq) |=> ovr);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !ovr_clr) |=> ovr);

endmodule

bind pulse_snapshot_sampler pss_checker #(.N_CH(N_CH), .TICK_DIV(TICK_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick_w),
  .en      (en_w),
  .irq     (irq_w),
  .ovr     (ovr_w),
  .irq_clr (irq_clr_w),
  .ovr_clr (ovr_clr_w),
  .sync_q  (sync_q),
  .snap    (snap_q)
);

// File: tb/pulse_snapshot_sampler_test.sv
module pulse_snapshot_sampler_test;

  localparam int CLK_PERIOD = 10;
  localparam int CH   = 80;
  localparam int DIV  = 24;
  localparam int AW   = 4;
  localparam int NB   = (CH + 7) / 8;
  localparam int STAT = NB;
  localparam int NVEC = 5;

  // Stimulus table; expected bytes are the same bits read back (R4, no inversion).
  localparam logic [CH-1:0] VEC [NVEC] = '{
    80'h0000_0000_0000_0000_0001,
    80'h8000_0000_0000_0000_0000,
    80'hFFFF_FFFF_FFFF_FFFF_FFFF,
    80'hA5A5_5A5A_0F0F_F0F0_3C3C,
    80'h1234_5678_9ABC_DEF0_2468
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CH-1:0] pulse_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  pulse_snapshot_sampler #(.N_CH(CH), .TICK_DIV(DIV), .ADDR_W(AW)) uut (
    .clk       (clk),
    .rst       (rst),
    .pulse_in  (pulse_in),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input int a, output logic [7:0] v);
    bus_addr = AW'(a);
    bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    bus_addr = AW'(STAT);
    bus_wdata = v;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    while (irq_o !== 1'b1 && n < 4*DIV) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(irq_o), 32'd1);
  endtask

  task automatic check_snapshot(input string req, input logic [CH-1:0] exp);
    logic [7:0] v;
    for (int b = 0; b < NB; b++) begin
      rd_byte(b, v);
      chk(req, 32'(v), 32'(exp[b*8 +: 8]));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    int n;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", 32'(irq_o), 32'd0);
    rd_byte(STAT, v);
    chk("R1 status after reset", 32'(v), 32'd0);
    rd_byte(0, v);
    chk("R1 byte0 after reset", 32'(v), 32'd0);

    // R10: disabled, no interrupt
    pulse_in = VEC[0];
    repeat (3*DIV) @(negedge clk);
    chk("R10 no irq while disabled", 32'(irq_o), 32'd0);

    // R2: first irq exactly DIV edges after enabling write
    wr_ctl(8'h01);
    n = 0;
    while (irq_o !== 1'b1 && n < 4*DIV) begin
      @(negedge clk);
      n++;
    end
    chk("R2 first tick latency", 32'(n), 32'(DIV));
    chk("R5 irq raised", 32'(irq_o), 32'd1);

    // Table walk: R3/R4 snapshot contents, R6 read-last clears irq
    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) wait_irq("R5 irq per tick");
      check_snapshot("R3 R4 snapshot bytes", VEC[i]);
      chk("R6 irq cleared by last byte read", 32'(irq_o), 32'd0);
      rd_byte(STAT, v);
      chk("R11 status en no overrun", 32'(v), 32'h01);
      if (i + 1 < NVEC) pulse_in = VEC[i+1];
    end

    // R6: reading a middle byte leaves irq set
    wait_irq("R5 irq");
    rd_byte(4, v);
    chk("R6 middle read keeps irq", 32'(irq_o), 32'd1);
    rd_byte(12, v);
    chk("R11 unmapped address reads 0", 32'(v), 32'd0);

    // R8: miss a tick, snapshot replaced, overrun set
    pulse_in = VEC[3];
    repeat (DIV + 2) @(negedge clk);
    rd_byte(STAT, v);
    chk("R8 overrun flag set", 32'(v), 32'h07);
    rd_byte(0, v);
    chk("R8 newer data replaced", 32'(v), 32'(VEC[3][7:0]));

    // R7: write clear of irq; R9 overrun stays
    wr_ctl(8'h03);
    chk("R7 irq cleared by write", 32'(irq_o), 32'd0);
    rd_byte(STAT, v);
    chk("R9 overrun sticky", 32'(v[2]), 32'd1);
    wr_ctl(8'h05);
    rd_byte(STAT, v);
    chk("R9 overrun cleared by write", 32'(v[2]), 32'd0);

    // R10: disable, then re-enable restarts full count
    wr_ctl(8'h06);
    repeat (3*DIV) @(negedge clk);
    chk("R10 no irq after disable", 32'(irq_o), 32'd0);

    // R12: late change (after edge DIV-2) is not captured
    pulse_in = VEC[2];
    wr_ctl(8'h01);
    repeat (DIV - 2) @(negedge clk);
    pulse_in = VEC[0];
    @(negedge clk);
    chk("R2 R10 no irq one edge early", 32'(irq_o), 32'd0);
    @(negedge clk);
    chk("R2 R10 irq after restart count", 32'(irq_o), 32'd1);
    rd_byte(0, v);
    chk("R12 late change missed byte0", 32'(v), 32'(VEC[2][7:0]));
    rd_byte(9, v);
    chk("R12 late change missed byte9", 32'(v), 32'(VEC[2][79:72]));

    // R12: change one edge earlier is captured
    wr_ctl(8'h06);
    pulse_in = VEC[2];
    wr_ctl(8'h01);
    repeat (DIV - 3) @(negedge clk);
    pulse_in = VEC[4];
    wait_irq("R12 irq");
    rd_byte(0, v);
    chk("R12 timely change captured", 32'(v), 32'(VEC[4][7:0]));

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after mid reset", 32'(irq_o), 32'd0);
    rd_byte(STAT, v);
    chk("R1 status after mid reset", 32'(v), 32'd0);
    rd_byte(0, v);
    chk("R1 snapshot after mid reset", 32'(v), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule